// File: doc/BRIEF.md
# Auto-Retry Lamp Driver Controller

This block is the digital control for a low-side switch that drives a warning lamp or an LED. A host command requests the lamp on or off. The block turns that request into a gate enable, and analog sense flags can override it. When the switch turns on, a cold filament draws a large inrush current. For that reason the short-to-battery comparator is ignored for a blanking window after every turn-on.

Once the blanking window has passed, a drain-high flag means the load is shorted. The block then switches the gate off and waits a retry interval. After that interval it turns the gate back on, with a fresh blanking window, for as long as the command stays high. The host is never told about a fault and never has to clear one.

Thermal and supply flags act differently from a short:
- Over-temperature and supply over-voltage mask the gate only while they are present.
- Supply under-voltage latches the lamp off until the host takes the command low and then high again.

All intervals are counted in ticks of a 1 µs strobe.

Top module: `lamp_retry_ctrl`

## Requirements
- R1: After reset `gate_en` is 0. With no other condition active, `lamp_cmd` high turns `gate_en` on at the next clock edge, and `lamp_cmd` low turns it off at the next clock edge.
- R2: `drain_high` is ignored while the controller is in its blanking phase. That phase starts at every turn-on, whether from the command or from a retry, and lasts `BLANK_TICKS` ticks.
- R3: After the blanking phase, `drain_high` sampled while `gate_en` is 1 turns `gate_en` off at the next clock edge.
- R4: After a short trip with `lamp_cmd` still high, `gate_en` stays 0 for exactly `RETRY_TICKS` ticks and then turns on again. A new blanking phase applies from that point.
- R5: `lamp_cmd` low cancels any pending retry or blanking count. A later rising command turns the gate on at the next edge, without waiting out the retry interval.
- R6: `hot_flag` high forces `gate_en` to 0 in the same cycle, whatever the command. When it clears with the command still high, the gate returns on in the same cycle.
- R7: `supply_over` high forces `gate_en` to 0 in the same cycle. When it clears, the gate returns to the state it had before.
- R8: `supply_under` high forces `gate_en` to 0 in the same cycle. The gate then stays 0 after the flag clears, until `lamp_cmd` has been sampled low and is then driven high again.
- R9: The blanking and retry counts advance only on clock edges where `tick_us` is 1. The count does not advance while `tick_us` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lamp_cmd | input | 1 | Lamp request from host, 1 = on |
| tick_us | input | 1 | One-cycle strobe marking each microsecond |
| drain_high | input | 1 | Drain above short threshold while the switch is on |
| hot_flag | input | 1 | Switch over-temperature |
| supply_over | input | 1 | Supply over-voltage |
| supply_under | input | 1 | Supply under-voltage |
| gate_en | output | 1 | Gate enable of the low-side switch |

## Verification
The assertions assume that all flag inputs are already synchronous to `clk`. They also assume that `tick_us` is a single-cycle strobe, never held high as a level except when the bench deliberately ticks on every cycle. The bench changes every input only at the falling edge of the clock. It uses short blanking and retry counts, so several complete retry cycles fit in one run. Fault flags are held stable across the edges on which the expected behaviour is sampled. Tick gating is exercised by stopping `tick_us` completely and not by changing its rate.

// File: rtl/lamp_pkg.sv
package lamp_pkg;

  typedef enum logic [1:0] {
    LS_OFF   = 2'd0,
    LS_BLANK = 2'd1,
    LS_ON    = 2'd2,
    LS_WAIT  = 2'd3
  } lamp_state_e;

  // Width needed to hold counts 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Last tick of an interval of 'len' ticks has arrived
  function automatic logic interval_last(input int unsigned cnt, input int unsigned len);
    return (len == 0) || (cnt + 1 >= len);
  endfunction

  // Gate permitted by the analog flags
  function automatic logic flags_allow(input logic hot, input logic ov,
                                       input logic uv, input logic locked);
    return !(hot || ov || uv || locked);
  endfunction

endpackage

// File: rtl/lamp_interval_timer.sv
module lamp_interval_timer #(
  parameter int unsigned CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expire
);
  import lamp_pkg::*;

  logic [CW-1:0] cnt_q;

  assign expire = run && tick && interval_last(int'(cnt_q), int'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || expire) begin
      cnt_q <= '0;
    end else if (run && tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/lamp_supply_guard.sv
module lamp_supply_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd,
  input  logic drive_req,
  input  logic hot,
  input  logic ov,
  input  logic uv,
  output logic uv_locked,
  output logic gate
);
  import lamp_pkg::*;

  logic lock_q;

  // Under-voltage latches; release needs the command sampled low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (uv) begin
      lock_q <= 1'b1;
    end else if (!cmd) begin
      lock_q <= 1'b0;
    end
  end

  assign uv_locked = lock_q;
  assign gate      = drive_req && flags_allow(hot, ov, uv, lock_q);

endmodule

// File: rtl/lamp_seq.sv
module lamp_seq #(
  parameter int unsigned BLANK_TICKS = 7000,
  parameter int unsigned RETRY_TICKS = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd,
  input  logic tick,
  input  logic short_seen,
  input  logic gate_now,
  input  logic uv,
  input  logic uv_locked,
  output logic drive_req,
  output logic blank_active,
  output logic on_active,
  output logic retry_wait
);
  import lamp_pkg::*;

  localparam int unsigned MAXT = (BLANK_TICKS > RETRY_TICKS) ? BLANK_TICKS : RETRY_TICKS;
  localparam int unsigned CW   = cnt_width(MAXT);
  localparam logic [CW-1:0] BLANK_LIM = CW'(BLANK_TICKS);
  localparam logic [CW-1:0] RETRY_LIM = CW'(RETRY_TICKS);

  lamp_state_e st_q, st_d;
  logic        t_clr, t_run, t_exp;
  logic [CW-1:0] t_lim;

  always_comb begin
    st_d = st_q;
    if (uv || !cmd) begin
      st_d = LS_OFF;
    end else begin
      unique case (st_q)
        LS_OFF:   if (!uv_locked) st_d = LS_BLANK;
        LS_BLANK: if (t_exp) st_d = LS_ON;
        LS_ON:    if (short_seen && gate_now) st_d = LS_WAIT;
        LS_WAIT:  if (t_exp) st_d = LS_BLANK;
        default:  st_d = LS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LS_OFF;
    else        st_q <= st_d;
  end

  assign blank_active = (st_q == LS_BLANK);
  assign on_active    = (st_q == LS_ON);
  assign retry_wait   = (st_q == LS_WAIT);
  assign drive_req    = blank_active || on_active;

  assign t_run = blank_active || retry_wait;
  assign t_clr = (st_d != st_q) || (st_q == LS_OFF);
  assign t_lim = blank_active ? BLANK_LIM : RETRY_LIM;

  lamp_interval_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (t_clr),
    .run    (t_run),
    .tick   (tick),
    .limit  (t_lim),
    .expire (t_exp)
  );

endmodule

// File: rtl/lamp_retry_ctrl.sv
module lamp_retry_ctrl #(
  parameter int unsigned BLANK_TICKS = 7000,
  parameter int unsigned RETRY_TICKS = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lamp_cmd,
  input  logic tick_us,
  input  logic drain_high,
  input  logic hot_flag,
  input  logic supply_over,
  input  logic supply_under,
  output logic gate_en
);

  logic drive_req;
  logic blank_active;
  logic on_active;
  logic retry_wait;
  logic uv_locked;

  lamp_seq #(
    .BLANK_TICKS (BLANK_TICKS),
    .RETRY_TICKS (RETRY_TICKS)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (lamp_cmd),
    .tick         (tick_us),
    .short_seen   (drain_high),
    .gate_now     (gate_en),
    .uv           (supply_under),
    .uv_locked    (uv_locked),
    .drive_req    (drive_req),
    .blank_active (blank_active),
    .on_active    (on_active),
    .retry_wait   (retry_wait)
  );

  lamp_supply_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (lamp_cmd),
    .drive_req (drive_req),
    .hot       (hot_flag),
    .ov        (supply_over),
    .uv        (supply_under),
    .uv_locked (uv_locked),
    .gate      (gate_en)
  );

endmodule

// File: rtl/lamp_retry_ctrl_chk.sv
module lamp_retry_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic lamp_cmd,
  input logic tick_us,
  input logic drain_high,
  input logic hot_flag,
  input logic supply_over,
  input logic supply_under,
  input logic gate_en,
  input logic blank_active,
  input logic on_active,
  input logic retry_wait,
  input logic uv_locked
);

  // R1
  cmd_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lamp_cmd |=> !gate_en);

  // R2
  blank_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_active && lamp_cmd && !supply_under) |=> (blank_active || on_active));

  // R3
  short_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_active && drain_high && gate_en && lamp_cmd && !supply_under) |=> retry_wait);

  // R4
  retry_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_wait |-> !gate_en);

  // R6
  hot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hot_flag |-> !gate_en);

  // R7
  over_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_over |-> !gate_en);

  // R8
  under_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_under || uv_locked) |=> !gate_en);

  // R9
  blank_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_us && blank_active && lamp_cmd && !supply_under) |=> blank_active);

  // R9
  retry_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_us && retry_wait && lamp_cmd && !supply_under) |=> retry_wait);

endmodule

bind lamp_retry_ctrl lamp_retry_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lamp_cmd     (lamp_cmd),
  .tick_us      (tick_us),
  .drain_high   (drain_high),
  .hot_flag     (hot_flag),
  .supply_over  (supply_over),
  .supply_under (supply_under),
  .gate_en      (gate_en),
  .blank_active (blank_active),
  .on_active    (on_active),
  .retry_wait   (retry_wait),
  .uv_locked    (uv_locked)
);

// File: tb/lamp_retry_ctrl_bench.sv
`timescale 1ns/100ps
module lamp_retry_ctrl_bench;

  localparam int B = 6;
  localparam int R = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lamp_cmd = 1'b0;
  logic tick_us = 1'b1;
  logic drain_high = 1'b0;
  logic hot_flag = 1'b0;
  logic supply_over = 1'b0;
  logic supply_under = 1'b0;
  logic gate_en;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  lamp_retry_ctrl #(.BLANK_TICKS(B), .RETRY_TICKS(R)) u_lamp_retry_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .lamp_cmd     (lamp_cmd),
    .tick_us      (tick_us),
    .drain_high   (drain_high),
    .hot_flag     (hot_flag),
    .supply_over  (supply_over),
    .supply_under (supply_under),
    .gate_en      (gate_en)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side: push the expected gate value for this point
  task automatic expect_gate(input logic e, input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    #2;
  endtask

  // monitor side: pop and compare
  initial begin
    forever begin
      item_t it;
      wait (sb_q.size() != 0);
      #1;
      it = sb_q.pop_front();
      checks++;
      if (gate_en !== it.exp) begin
        fails++;
        $display("FAIL %s: gate_en actual=%b expected=%b", it.tag, gate_en, it.exp);
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(2);
    expect_gate(1'b0, "R1 reset");
    rst_n = 1'b1;
    cyc(1);
    expect_gate(1'b0, "R1 idle");

    // turn-on with short present from the start
    lamp_cmd = 1'b1; drain_high = 1'b1;
    cyc(1); expect_gate(1'b1, "R1 on");
    cyc(B - 1); expect_gate(1'b1, "R2 blanking masks short");
    cyc(1); expect_gate(1'b1, "R2 last blanking tick");
    cyc(1); expect_gate(1'b0, "R3 short trip");
    cyc(R - 1); expect_gate(1'b0, "R4 retry wait");
    cyc(1); expect_gate(1'b1, "R4 retry on");
    cyc(B); expect_gate(1'b1, "R4 blanking again");
    cyc(1); expect_gate(1'b0, "R4 trip again");

    // cancel the retry with the command
    drain_high = 1'b0;
    cyc(2);
    lamp_cmd = 1'b0;
    cyc(2); expect_gate(1'b0, "R5 command low");
    lamp_cmd = 1'b1;
    cyc(1); expect_gate(1'b1, "R5 fresh turn-on");
    cyc(B + 3); expect_gate(1'b1, "R3 no short stays on");
    lamp_cmd = 1'b0;
    cyc(1); expect_gate(1'b0, "R1 off");

    // over-temperature
    lamp_cmd = 1'b1;
    cyc(B + 3);
    hot_flag = 1'b1;
    expect_gate(1'b0, "R6 hot forces off");
    drain_high = 1'b1;
    cyc(3); expect_gate(1'b0, "R6 hot held");
    drain_high = 1'b0;
    cyc(1);
    hot_flag = 1'b0;
    expect_gate(1'b1, "R6 resume");

    // over-voltage
    cyc(2);
    supply_over = 1'b1;
    expect_gate(1'b0, "R7 over forces off");
    cyc(4);
    supply_over = 1'b0;
    expect_gate(1'b1, "R7 restore on");
    lamp_cmd = 1'b0;
    cyc(2);
    supply_over = 1'b1;
    cyc(2);
    supply_over = 1'b0;
    cyc(1); expect_gate(1'b0, "R7 restore off");

    // under-voltage latch
    lamp_cmd = 1'b1;
    cyc(B + 3); expect_gate(1'b1, "R8 on before");
    supply_under = 1'b1;
    expect_gate(1'b0, "R8 under forces off");
    cyc(3);
    supply_under = 1'b0;
    cyc(1); expect_gate(1'b0, "R8 still off");
    cyc(B + R); expect_gate(1'b0, "R8 latched");
    lamp_cmd = 1'b0;
    cyc(1);
    lamp_cmd = 1'b1;
    cyc(1); expect_gate(1'b1, "R8 re-enabled");
    lamp_cmd = 1'b0;
    cyc(2);

    // tick gating
    tick_us = 1'b0;
    lamp_cmd = 1'b1; drain_high = 1'b1;
    cyc(3 * B); expect_gate(1'b1, "R9 blanking frozen");
    tick_us = 1'b1;
    cyc(B); expect_gate(1'b1, "R9 blanking resumes");
    cyc(1); expect_gate(1'b0, "R9 trip after ticks");
    tick_us = 1'b0;
    cyc(3 * R); expect_gate(1'b0, "R9 retry frozen");
    tick_us = 1'b1;
    cyc(R); expect_gate(1'b1, "R9 retry after ticks");

    cyc(2);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule